// File: doc/BRIEF.md
# SD Command Issue Gate

This block sits beside the register file of an SD host controller. It decides whether a command that software has just written may go to the card. The decision uses the SD clock enable, the power state, the data-line busy state and the kind of command. The block also holds two vendor control words.

The first vendor word holds two power-check qualifiers and a buffer-read blanking bit. The second vendor word is plain storage with a non-zero reset value. The block also forces the clock-stable status bit each time software writes the clock control register.

Software reaches the registers over a simple bus:
- Writes are single-cycle, with byte enables.
- Reads are combinational.

A command write that touches the command-type byte produces, one cycle later, a one-cycle pulse on exactly one of two outputs: go or deny.

Top module: `sd_issue_gate`

## Requirements
- R1: After reset the following values hold:
  - vendor word 0 (byte address 0x80) reads 0x00000000;
  - vendor word 1 (0x84) reads 0x7F5F3F1F;
  - clock control (0x2C, bits 15:0) and power control (0x28, bits 15:8) read zero;
  - issue_go_o, issue_deny_o and clk_stable_o are low.
- R2: Writes to either vendor word update only the byte lanes whose enable is set. Lane k covers bits 8k+7:8k, on a little-endian bus.
- R3: A write to the command word (0x0C) with byte enable 3 set yields, one cycle later, a pulse on exactly one of issue_go_o and issue_deny_o. Any other write leaves both low. The new command (bits 31:16 of the word) is the value judged.
- R4: A command is denied when SD clock enable (clock control bit 2) is 0.
- R5: With power control bit 8 of word 0x28 low, a command is denied only if vendor word 0 bit 12 or bit 3 is set. Otherwise power is treated as present.
- R6: A command uses the data lines when its data-present bit (command bit 5) is 1 or its response type (bits 1:0) is 2'b11. Such a command is denied while data_inhibit_i or xfer_stopped_i is high, unless its type field (bits 7:6) is 2'b11 (abort).
- R7: A command that does not use the data lines is not blocked by data_inhibit_i or xfer_stopped_i.
- R8: A write to clock control with byte enable 0 sets clock-stable (bit 3) to 1 if written bit 2 is 1 and card_present_i is high. Otherwise the bit is cleared. A write without byte enable 0 leaves it unchanged.
- R9: The buffer data port (0x20) reads buf_data_i, or zero while vendor word 0 bit 6 is set.
- R10: clk_stable_o always equals bit 3 of the clock control register as read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address, word aligned |
| reg_wdata_i | input | 32 | Write data |
| reg_be_i | input | 4 | Byte enables |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| card_present_i | input | 1 | Card inserted |
| data_inhibit_i | input | 1 | Data lines busy |
| xfer_stopped_i | input | 1 | Transfer halted mid-stream |
| buf_data_i | input | 32 | Buffer data port value |
| issue_go_o | output | 1 | Command accepted pulse |
| issue_deny_o | output | 1 | Command refused pulse |
| clk_stable_o | output | 1 | Clock-stable status bit |

## Verification
The hardest case to reach is a denial that depends on three separately written states at once. One example is a power-off refusal, which needs the clock enabled, power cleared and a qualifier bit set, all before the command-type byte lands. Another is a busy refusal, which also needs the command's own type and response bits set in a specific way.

The bench reaches these cases by walking a vector table. For each vector it rewrites clock, power and vendor word 0 and sets the busy inputs, then writes the command. The go and deny pulses are checked on the following cycle. Directed tests then cover:
- partial-lane writes;
- clock writes with the card absent;
- writes that miss the command-type byte.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
  localparam int unsigned CLK_SD_EN   = 2;
  localparam int unsigned CLK_STABLE  = 3;
  localparam int unsigned PWR_ON      = 0;
  localparam int unsigned VC_PWR_A    = 12;
  localparam int unsigned VC_PWR_B    = 3;
  localparam int unsigned VC_BUF_MASK = 6;
  localparam int unsigned CMD_DATA    = 5;
  localparam logic [1:0]  RSP_BUSY    = 2'b11;
  localparam logic [1:0]  TYPE_ABORT  = 2'b11;

  function automatic logic cmd_uses_dat(input logic [15:0] cmd);
    return cmd[CMD_DATA] || (cmd[1:0] == RSP_BUSY);
  endfunction
endpackage

// File: rtl/sdg_lane_reg.sv
module sdg_lane_reg #(
  parameter int unsigned  LANES = 4,
  parameter logic [LANES*8-1:0] RST_VAL = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [LANES*8-1:0] wdata_i,
  output logic [LANES*8-1:0] q_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[k*8 +: 8] <= RST_VAL[k*8 +: 8];
      else if (we_i && be_i[k])   q_o[k*8 +: 8] <= wdata_i[k*8 +: 8];
    end

    a_r2_lane_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && be_i[k]) |=> $stable(q_o[k*8 +: 8]));
  end
endmodule

// File: rtl/sdg_clk_ctl.sv
module sdg_clk_ctl
  import sdg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] wdata_i,
  input  logic        card_present_i,
  output logic [15:0] q_o
);
  logic [7:0] lo_d;

  // stable bit is not software writable: forced from enable and card presence
  always_comb begin
    lo_d = wdata_i[7:0];
    lo_d[CLK_STABLE] = wdata_i[CLK_SD_EN] && card_present_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (we_i) begin
      if (be_i[0]) q_o[7:0]  <= lo_d;
      if (be_i[1]) q_o[15:8] <= wdata_i[15:8];
    end
  end

  a_r8_stable_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && be_i[0]) |=> q_o[CLK_STABLE] == $past(wdata_i[CLK_SD_EN] && card_present_i));
  a_r8_stable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && be_i[0]) |=> $stable(q_o[CLK_STABLE]));
endmodule

// File: rtl/sdg_issue_eval.sv
module sdg_issue_eval
  import sdg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  logic [15:0] cmd_i,
  input  logic [15:0] clk_ctl_i,
  input  logic        pwr_on_i,
  input  logic [31:0] vc0_i,
  input  logic        data_inhibit_i,
  input  logic        xfer_stopped_i,
  output logic        go_o,
  output logic        deny_o
);
  logic clk_ok, pwr_ok, dat_ok, allow;

  always_comb begin
    clk_ok = clk_ctl_i[CLK_SD_EN];
    pwr_ok = pwr_on_i || !(vc0_i[VC_PWR_A] || vc0_i[VC_PWR_B]);
    dat_ok = !((data_inhibit_i || xfer_stopped_i) && cmd_uses_dat(cmd_i)
               && (cmd_i[7:6] != TYPE_ABORT));
    allow  = clk_ok && pwr_ok && dat_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_o   <= 1'b0;
      deny_o <= 1'b0;
    end else begin
      go_o   <= cmd_wr_i && allow;
      deny_o <= cmd_wr_i && !allow;
    end
  end

  a_r3_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(go_o && deny_o));
  a_r3_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i |=> (go_o || deny_o));
  a_r3_no_stray: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr_i |=> !(go_o || deny_o));
  a_r4_clk_off_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !clk_ctl_i[CLK_SD_EN]) |=> deny_o);
  a_r5_pwr_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && clk_ctl_i[CLK_SD_EN] && !vc0_i[VC_PWR_A] && !vc0_i[VC_PWR_B]
     && !data_inhibit_i && !xfer_stopped_i) |=> go_o);
endmodule

// File: rtl/sd_issue_gate.sv
module sd_issue_gate
  import sdg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned A_CMD    = 'h0C,
  parameter int unsigned A_BUF    = 'h20,
  parameter int unsigned A_PWR    = 'h28,
  parameter int unsigned A_CLK    = 'h2C,
  parameter int unsigned A_VC0    = 'h80,
  parameter int unsigned A_VC1    = 'h84,
  parameter logic [31:0] VC1_RST  = 32'h7F5F3F1F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [3:0]        reg_be_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              card_present_i,
  input  logic              data_inhibit_i,
  input  logic              xfer_stopped_i,
  input  logic [31:0]       buf_data_i,
  output logic              issue_go_o,
  output logic              issue_deny_o,
  output logic              clk_stable_o
);
  localparam logic [ADDR_W-1:0] W_CMD = ADDR_W'(A_CMD);
  localparam logic [ADDR_W-1:0] W_BUF = ADDR_W'(A_BUF);
  localparam logic [ADDR_W-1:0] W_PWR = ADDR_W'(A_PWR);
  localparam logic [ADDR_W-1:0] W_CLK = ADDR_W'(A_CLK);
  localparam logic [ADDR_W-1:0] W_VC0 = ADDR_W'(A_VC0);
  localparam logic [ADDR_W-1:0] W_VC1 = ADDR_W'(A_VC1);

  logic [ADDR_W-1:0] waddr;
  logic [15:0] cmd_q, cmd_new, clk_ctl;
  logic [7:0]  pwr_q;
  logic [31:0] vc0, vc1;
  logic sel_cmd, sel_pwr, sel_clk, sel_vc0, sel_vc1, cmd_wr;

  assign waddr   = {reg_addr_i[ADDR_W-1:2], 2'b00};
  assign sel_cmd = reg_we_i && (waddr == W_CMD);
  assign sel_pwr = reg_we_i && (waddr == W_PWR);
  assign sel_clk = reg_we_i && (waddr == W_CLK);
  assign sel_vc0 = reg_we_i && (waddr == W_VC0);
  assign sel_vc1 = reg_we_i && (waddr == W_VC1);
  assign cmd_wr  = sel_cmd && reg_be_i[3];

  // command judged on the value being written this cycle
  assign cmd_new = {reg_be_i[3] ? reg_wdata_i[31:24] : cmd_q[15:8],
                    reg_be_i[2] ? reg_wdata_i[23:16] : cmd_q[7:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      pwr_q <= '0;
    end else begin
      if (sel_cmd) cmd_q <= cmd_new;
      if (sel_pwr && reg_be_i[1]) pwr_q <= reg_wdata_i[15:8];
    end
  end

  sdg_lane_reg #(.LANES(4), .RST_VAL(32'h0)) u_vc0 (
    .clk_i, .rst_ni, .we_i(sel_vc0), .be_i(reg_be_i), .wdata_i(reg_wdata_i), .q_o(vc0));

  sdg_lane_reg #(.LANES(4), .RST_VAL(VC1_RST)) u_vc1 (
    .clk_i, .rst_ni, .we_i(sel_vc1), .be_i(reg_be_i), .wdata_i(reg_wdata_i), .q_o(vc1));

  sdg_clk_ctl u_clk (
    .clk_i, .rst_ni, .we_i(sel_clk), .be_i(reg_be_i[1:0]), .wdata_i(reg_wdata_i[15:0]),
    .card_present_i, .q_o(clk_ctl));

  sdg_issue_eval u_eval (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .cmd_i(cmd_new), .clk_ctl_i(clk_ctl),
    .pwr_on_i(pwr_q[PWR_ON]), .vc0_i(vc0), .data_inhibit_i, .xfer_stopped_i,
    .go_o(issue_go_o), .deny_o(issue_deny_o));

  assign clk_stable_o = clk_ctl[CLK_STABLE];

  always_comb begin
    unique case ({reg_addr_i[ADDR_W-1:2], 2'b00})
      W_CMD:   reg_rdata_o = {cmd_q, 16'h0};
      W_PWR:   reg_rdata_o = {16'h0, pwr_q, 8'h0};
      W_CLK:   reg_rdata_o = {16'h0, clk_ctl};
      W_BUF:   reg_rdata_o = vc0[VC_BUF_MASK] ? 32'h0 : buf_data_i;
      W_VC0:   reg_rdata_o = vc0;
      W_VC1:   reg_rdata_o = vc1;
      default: reg_rdata_o = 32'h0;
    endcase
  end

  always_comb begin
    if (rst_ni && ({reg_addr_i[ADDR_W-1:2], 2'b00} == W_BUF) && vc0[VC_BUF_MASK])
      a_r9_buf_blank: assert (reg_rdata_o == 32'h0);
  end
endmodule

// File: tb/tb_sd_issue_gate.sv
module tb_sd_issue_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // [23] clk en, [22] pwr, [21] vc0 bit12, [20] vc0 bit3, [19] inhibit, [18] stopped, [17] expect go, [15:0] cmd
  localparam logic [23:0] VEC [NV] = '{
    24'hC20000, 24'h400000, 24'h820000, 24'hA00000, 24'h900000, 24'hF20000,
    24'hC80020, 24'hC80003, 24'hC40020, 24'hCA00E0, 24'hCA0002, 24'hC60001,
    24'hC20023};

  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata, bufd = 32'hDEADBEEF;
  logic [3:0] be = 0;
  logic card = 1, inh = 0, stp = 0;
  logic go, deny, stable;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_issue_gate dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_be_i(be), .reg_rdata_o(rdata), .card_present_i(card), .data_inhibit_i(inh),
    .xfer_stopped_i(stp), .buf_data_i(bufd), .issue_go_o(go), .issue_deny_o(deny),
    .clk_stable_o(stable));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    we = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    we = 0; be = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(8'h80, v); chk("R1 vc0", v, 32'h0);
    rd(8'h84, v); chk("R1 vc1", v, 32'h7F5F3F1F);
    rd(8'h2C, v); chk("R1 clk", v, 32'h0);
    rd(8'h28, v); chk("R1 pwr", v, 32'h0);
    chk("R1 outs", {29'h0, go, deny, stable}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // Vector walk: R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(8'h2C, {29'h0, VEC[i][23], 2'b01}, 4'b0011);
      wr(8'h28, {16'h0, 7'h0, VEC[i][22], 8'h0}, 4'b0010);
      wr(8'h80, (32'(VEC[i][21]) << 12) | (32'(VEC[i][20]) << 3), 4'b1111);
      inh = VEC[i][19]; stp = VEC[i][18];
      wr(8'h0C, {VEC[i][15:0], 16'h0}, 4'b1100);
      chk($sformatf("R4/R5/R6/R7 vec%0d", i), {30'h0, go, deny}, {30'h0, VEC[i][17], !VEC[i][17]});
      inh = 0; stp = 0;
    end

    // R3: outcome pulse lasts one cycle
    @(negedge clk);
    chk("R3 pulse ends", {30'h0, go, deny}, 32'h0);
    // R3: command write without type byte gives no outcome
    wr(8'h0C, 32'h00200000, 4'b0100);
    chk("R3 no byte3", {30'h0, go, deny}, 32'h0);
    wr(8'h2C, 32'h5, 4'b0001);
    chk("R3 other write", {30'h0, go, deny}, 32'h0);
    // R3: merged command judged (lower byte 0x20 kept, busy inhibit -> deny)
    inh = 1;
    wr(8'h0C, 32'h00000000, 4'b1000);
    chk("R3 merged cmd", {30'h0, go, deny}, 32'h1);
    inh = 0;

    // R2 byte lanes
    wr(8'h84, 32'h0000AB00, 4'b0010);
    rd(8'h84, v); chk("R2 byte", v, 32'h7F5FAB1F);
    wr(8'h84, 32'h12340000, 4'b1100);
    rd(8'h84, v); chk("R2 half", v, 32'h1234AB1F);
    wr(8'h84, 32'hCAFEF00D, 4'b1111);
    rd(8'h84, v); chk("R2 word", v, 32'hCAFEF00D);

    // R8 / R10 clock stable
    card = 0;
    wr(8'h2C, 32'h5, 4'b0001);
    chk("R8 no card", {31'h0, stable}, 32'h0);
    card = 1;
    wr(8'h2C, 32'h5, 4'b0001);
    chk("R8 card", {31'h0, stable}, 32'h1);
    rd(8'h2C, v); chk("R10 readback", v, 32'h0000000D);
    wr(8'h2C, 32'h0000FF00, 4'b0010);
    chk("R8 hi byte hold", {31'h0, stable}, 32'h1);
    wr(8'h2C, 32'h8, 4'b0001);
    chk("R8 sd off", {31'h0, stable}, 32'h0);
    rd(8'h2C, v); chk("R10 cleared", v, 32'h0000FF00);

    // R9 buffer blanking
    wr(8'h80, 32'h0, 4'b1111);
    rd(8'h20, v); chk("R9 pass", v, 32'hDEADBEEF);
    wr(8'h80, 32'h40, 4'b0001);
    rd(8'h20, v); chk("R9 blank", v, 32'h0);
    wr(8'h80, 32'h0, 4'b0001);
    rd(8'h20, v); chk("R9 restore", v, 32'hDEADBEEF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule